// File: doc/BRIEF.md
# Asynchronous Serial Port with Address-Marking Bit

This block is an asynchronous serial transmitter and receiver that can append one extra marking bit after the eight data bits of every character. On a shared line, a bus master uses that bit to separate address characters (bit = 1) from data characters (bit = 0). Software sees four small registers: a transmit data register, a receive data register, a control register and a status register. The status register carries the transmit-empty and transmit-end flags, the marking bit of the last received character, and the marking bit to attach to the next character sent.

The work of the block is in the flag rules. Transmit-empty tells software that the data register can take a new byte. Transmit-end tells it that the line has gone quiet with nothing left to send. Software clears both with an access sequence: it first reads the status register, then writes a 0 to the empty flag. The bit-time base comes from a fixed divider that produces a tick at sixteen times the bit rate. The synchronous-mode control bit has only one effect here: it removes the marking bit from the frame.

Top module: `mpu_uart`

## Requirements
- R1: After reset the status register (address 3) reads 0x0C: bit 3 transmit-empty = 1, bit 2 transmit-end = 1, bit 1 received marking bit = 0, bit 0 marking bit to send = 0. The control register (address 2) reads 0 and the serial output is high.
- R2: In the control register, bit 0 enables transmit, bit 1 enables receive, bit 2 selects the marking format and bit 3 selects synchronous mode. A byte written to address 0 goes out as follows: a low start bit, eight data bits LSB first, the marking bit when control bit 2 = 1 and bit 3 = 0, then a high stop bit. Each bit lasts 16×TICK_DIV clocks and the line idles high.
- R3: The marking bit sent is status bit 0 as it stood when the character entered the shift register. A later write to status bit 0 does not alter a frame already under way.
- R4: When control bit 2 = 0 or control bit 3 = 1, no marking bit is inserted and the frame is 10 bits long.
- R5: A write to address 0 clears transmit-empty. Transmit-empty is set again when the held byte moves into the shift register, which happens in the next cycle if the shifter is idle and otherwise when the current frame ends.
- R6: A write to address 0 clears transmit-end. Transmit-end is set when the stop bit of a character completes while transmit-empty = 1, and stays 0 while a further character is pending.
- R7: A status write with bit 3 = 0 clears transmit-empty and transmit-end only if the status register was read with bit 3 = 1 since the previous status write. Otherwise the write has no effect on either flag. A clear that takes effect causes the byte held at address 0 to be sent again.
- R8: Clearing control bit 0 sets transmit-end, abandons any frame in progress and returns the line high.
- R9: Bus writes to status bit 2 have no effect. Status bit 0 is writable.
- R10: With receive enabled, every character received loads its byte into address 1. In the marking format, status bit 1 takes the received marking bit. Outside that format, status bit 1 keeps its value. Bus writes to status bit 1 have no effect.
- R11: With receive disabled, incoming frames are ignored, and address 1 and status bit 1 keep their values.
- R12: A low pulse on the receive line that is no longer low at the centre of the start bit is discarded and loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier, used together with bus_sel |
| bus_rd | input | 1 | Read qualifier, used together with bus_sel (arms the flag clear) |
| bus_addr | input | 2 | Register address: 0 transmit data, 1 receive data, 2 control, 3 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The properties assume single-cycle bus accesses in which bus_wr and bus_rd are never asserted together. The stimulus drives each access for exactly one clock, with the two qualifiers mutually exclusive. The receive-side checks assume that frames on rxd keep the programmed bit time and that the marking format is not changed while a frame is arriving. The bench changes the control register only while both lines are idle, except in the deliberate transmit abort. Glitches on the receive line are kept shorter than half a bit.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
   localparam logic [1:0] A_TXD  = 2'd0;
   localparam logic [1:0] A_RXD  = 2'd1;
   localparam logic [1:0] A_CTL  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   localparam int CTL_W      = 4;
   localparam int C_TX_EN    = 0;
   localparam int C_RX_EN    = 1;
   localparam int C_MARK_EN  = 2;
   localparam int C_SYNC     = 3;

   localparam int S_MARK_TX  = 0;
   localparam int S_MARK_RX  = 1;
   localparam int S_TX_END   = 2;
   localparam int S_TX_EMPTY = 3;

   localparam int OVS        = 16;
   localparam int OVS_W      = $clog2(OVS);

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_t;
endpackage

// File: rtl/mpu_baud.sv
module mpu_baud #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(TICK_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q == CW'(TICK_DIV - 1))
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == CW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx import mpu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              add_mark,
   input  logic              mark_val,
   output logic              txd,
   output logic              busy,
   output logic              done
);
   localparam int FW = DATA_W + 3;
   localparam int BW = $clog2(FW);

   logic [FW-1:0]    sh_q;
   logic [OVS_W-1:0] tcnt_q;
   logic [BW-1:0]    bidx_q;
   logic [BW-1:0]    last_q;
   logic             bit_end;

   assign bit_end = busy && tick && (tcnt_q == OVS_W'(OVS - 1));
   assign done    = bit_end && (bidx_q == last_q);
   assign txd     = busy ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         busy   <= 1'b0;
         tcnt_q <= '0;
         bidx_q <= '0;
         last_q <= '0;
      end else if (!en) begin
         sh_q   <= '1;
         busy   <= 1'b0;
         tcnt_q <= '0;
         bidx_q <= '0;
      end else if (load) begin
         // marking bit value is frozen here for the whole frame
         sh_q   <= {1'b1, (add_mark ? mark_val : 1'b1), din, 1'b0};
         busy   <= 1'b1;
         tcnt_q <= '0;
         bidx_q <= '0;
         last_q <= add_mark ? BW'(FW - 1) : BW'(FW - 2);
      end else if (busy && tick) begin
         tcnt_q <= tcnt_q + 1'b1;
         if (bit_end) begin
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            bidx_q <= bidx_q + 1'b1;
            if (bidx_q == last_q)
               busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx import mpu_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rxd,
   input  logic              mark_fmt,
   output logic              done,
   output logic              had_mark,
   output logic [DATA_W-1:0] dout,
   output logic              mark_bit
);
   localparam int BW = $clog2(DATA_W + 2);

   rx_state_t        st_q;
   logic [1:0]       sync_q;
   logic             rxs;
   logic [OVS_W-1:0] tcnt_q;
   logic [BW-1:0]    bidx_q;
   logic [BW-1:0]    last_q;
   logic             sample;

   assign rxs    = sync_q[1];
   assign sample = (st_q == RX_BITS) && tick && (tcnt_q == OVS_W'(OVS - 1));
   assign done   = sample && (bidx_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RX_IDLE;
         tcnt_q   <= '0;
         bidx_q   <= '0;
         last_q   <= '0;
         had_mark <= 1'b0;
         dout     <= '0;
         mark_bit <= 1'b0;
      end else if (!en) begin
         st_q <= RX_IDLE;
      end else begin
         unique case (st_q)
            RX_IDLE: if (!rxs) begin
               st_q     <= RX_START;
               tcnt_q   <= '0;
               had_mark <= mark_fmt;
               last_q   <= mark_fmt ? BW'(DATA_W + 1) : BW'(DATA_W);
            end
            RX_START: if (tick) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (tcnt_q == OVS_W'(OVS / 2 - 1)) begin
                  tcnt_q <= '0;
                  bidx_q <= '0;
                  st_q   <= rxs ? RX_IDLE : RX_BITS;
               end
            end
            RX_BITS: if (tick) begin
               tcnt_q <= tcnt_q + 1'b1;
               if (sample) begin
                  if (bidx_q < BW'(DATA_W))
                     dout <= {rxs, dout[DATA_W-1:1]};
                  else if (had_mark && bidx_q == BW'(DATA_W))
                     mark_bit <= rxs;
                  bidx_q <= bidx_q + 1'b1;
                  if (bidx_q == last_q)
                     st_q <= RX_IDLE;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart import mpu_pkg::*; #(
   parameter int DATA_W   = 8,
   parameter int TICK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rxd,
   output logic              txd
);
   generate
      if (DATA_W < CTL_W) begin : g_bad_width
         $error("DATA_W must cover the control and status fields");
      end
   endgenerate

   logic [DATA_W-1:0] tx_hold_q, rx_data_q;
   logic [CTL_W-1:0]  ctl_q;
   logic tx_empty_q, tx_end_q, mark_rx_q, mark_tx_q, armed_q;
   logic tick, tx_busy, tx_done, tx_load;
   logic rx_done, rx_had_mark, rx_mark;
   logic [DATA_W-1:0] rx_byte;
   logic wr_txd, wr_ctl, wr_stat, rd_stat, clr_ok;
   logic tx_en, rx_en, mark_fmt;

   assign tx_en    = ctl_q[C_TX_EN];
   assign rx_en    = ctl_q[C_RX_EN];
   assign mark_fmt = ctl_q[C_MARK_EN] && !ctl_q[C_SYNC];

   assign wr_txd  = bus_sel && bus_wr && (bus_addr == A_TXD);
   assign wr_ctl  = bus_sel && bus_wr && (bus_addr == A_CTL);
   assign wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
   assign rd_stat = bus_sel && bus_rd && (bus_addr == A_STAT);
   assign clr_ok  = wr_stat && armed_q && !bus_wdata[S_TX_EMPTY];
   assign tx_load = tx_en && !tx_empty_q && !tx_busy;

   mpu_baud #(.TICK_DIV(TICK_DIV)) u_baud (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   mpu_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick), .load(tx_load),
      .din(tx_hold_q), .add_mark(mark_fmt), .mark_val(mark_tx_q),
      .txd(txd), .busy(tx_busy), .done(tx_done)
   );

   mpu_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rxd(rxd),
      .mark_fmt(mark_fmt), .done(rx_done), .had_mark(rx_had_mark),
      .dout(rx_byte), .mark_bit(rx_mark)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold_q  <= '0;
         rx_data_q  <= '0;
         ctl_q      <= '0;
         tx_empty_q <= 1'b1;
         tx_end_q   <= 1'b1;
         mark_rx_q  <= 1'b0;
         mark_tx_q  <= 1'b0;
         armed_q    <= 1'b0;
      end else begin
         if (wr_txd) tx_hold_q <= bus_wdata;
         if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
         if (wr_stat) mark_tx_q <= bus_wdata[S_MARK_TX];

         if (wr_stat)
            armed_q <= 1'b0;
         else if (rd_stat && tx_empty_q)
            armed_q <= 1'b1;

         if (wr_txd || clr_ok)
            tx_empty_q <= 1'b0;
         else if (tx_load)
            tx_empty_q <= 1'b1;

         if (!tx_en)
            tx_end_q <= 1'b1;
         else if (wr_txd || clr_ok)
            tx_end_q <= 1'b0;
         else if (tx_done && tx_empty_q)
            tx_end_q <= 1'b1;

         if (rx_done && rx_en) begin
            rx_data_q <= rx_byte;
            if (rx_had_mark) mark_rx_q <= rx_mark;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_TXD: bus_rdata = tx_hold_q;
         A_RXD: bus_rdata = rx_data_q;
         A_CTL: bus_rdata[CTL_W-1:0] = ctl_q;
         default: begin
            bus_rdata[S_TX_EMPTY] = tx_empty_q;
            bus_rdata[S_TX_END]   = tx_end_q;
            bus_rdata[S_MARK_RX]  = mark_rx_q;
            bus_rdata[S_MARK_TX]  = mark_tx_q;
         end
      endcase
   end
endmodule

// File: rtl/mpu_uart_chk.sv
module mpu_uart_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic rx_en,
   input logic txd,
   input logic tx_empty,
   input logic tx_end,
   input logic mark_rx,
   input logic tx_done,
   input logic tx_load,
   input logic data_wr,
   input logic clr_ok
);
   AST_LINE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> txd); // R2

   AST_END_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tx_end); // R8

   AST_MARK_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> $stable(mark_rx)); // R11

   AST_END_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_end) |-> $past(!tx_en || (tx_done && tx_empty))); // R6

   AST_EMPTY_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(data_wr || clr_ok)); // R7

   AST_EMPTY_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(tx_load)); // R5
endmodule

bind mpu_uart mpu_uart_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .txd(txd),
   .tx_empty(tx_empty_q), .tx_end(tx_end_q), .mark_rx(mark_rx_q),
   .tx_done(tx_done), .tx_load(tx_load), .data_wr(wr_txd), .clr_ok(clr_ok)
);

// File: tb/mpu_uart_tb.sv
`timescale 1ns/1ps
module mpu_uart_tb;
   localparam int DATA_W   = 8;
   localparam int TICK_DIV = 4;
   localparam int CP       = 4;
   localparam int BPNS     = 16 * TICK_DIV * CP;

   typedef struct {
      logic [7:0] d;
      bit         has;
      bit         mk;
      string      tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
   logic [1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
   logic rxd = 1'b1, txd;

   int n_run = 0, n_fail = 0;
   bit mon_en = 1, mon_busy = 0, finished = 0;
   item_t exp_q[$];

   always #(CP/2) clk = ~clk;

   mpu_uart #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bwrite(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bread(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] mask,
                         input logic [7:0] exp, input string req, input string what);
      logic [7:0] v;
      bread(a, v);
      chk((v & mask) == exp, req, what, int'(v & mask), int'(exp));
   endtask

   // driver: queue the frame the monitor must see, then write the byte
   task automatic send_tx(input logic [7:0] d, input bit has, input bit mk, input string tag);
      item_t it;
      it.d = d; it.has = has; it.mk = mk; it.tag = tag;
      exp_q.push_back(it);
      bwrite(2'd0, d);
   endtask

   task automatic push_exp(input logic [7:0] d, input bit has, input bit mk, input string tag);
      item_t it;
      it.d = d; it.has = has; it.mk = mk; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic wait_tx();
      wait (exp_q.size() == 0 && !mon_busy);
      #(BPNS);
   endtask

   task automatic send_rx(input logic [7:0] d, input bit has, input bit mk);
      @(negedge clk);
      rxd = 0; #(BPNS);
      for (int i = 0; i < 8; i++) begin rxd = d[i]; #(BPNS); end
      if (has) begin rxd = mk; #(BPNS); end
      rxd = 1; #(BPNS);
      #(BPNS);
   endtask

   // monitor: decode each frame on txd and compare with the queue head
   initial begin
      forever begin
         item_t it;
         logic [7:0] got;
         logic st, mk, sp;
         @(negedge txd);
         if (!mon_en) continue;
         mon_busy = 1;
         #(BPNS/2 + 1);
         st = txd;
         if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected frame start", 0, 1);
            #(10 * BPNS);
            mon_busy = 0;
            continue;
         end
         it = exp_q.pop_front();
         for (int i = 0; i < 8; i++) begin #(BPNS); got[i] = txd; end
         mk = 1'b0;
         if (it.has) begin #(BPNS); mk = txd; end
         #(BPNS); sp = txd;
         chk(st == 1'b0, "R2", "start bit", st, 0);
         chk(got == it.d, it.tag, "frame data", got, it.d);
         if (it.has) chk(mk == it.mk, it.tag, "marking bit", mk, it.mk);
         chk(sp == 1'b1, it.tag, "stop bit / frame length", sp, 1);
         mon_busy = 0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rd_chk(2'd3, 8'hFF, 8'h0C, "R1", "status after reset");
      rd_chk(2'd2, 8'hFF, 8'h00, "R1", "control after reset");
      chk(txd == 1'b1, "R1", "line idle after reset", txd, 1);

      bwrite(2'd2, 8'h07);
      bwrite(2'd3, 8'h09);
      rd_chk(2'd3, 8'hFF, 8'h0D, "R9", "marking bit to send writable");

      // R2/R3: frame with marking bit 1, then change bit 0 mid-frame
      send_tx(8'h5A, 1, 1, "R3");
      rd_chk(2'd3, 8'hFF, 8'h09, "R5", "byte moved to shifter, end cleared");
      bwrite(2'd3, 8'h0C);
      rd_chk(2'd3, 8'hFF, 8'h08, "R9", "write to end bit ignored");
      wait_tx();
      rd_chk(2'd3, 8'hFF, 8'h0C, "R6", "end set after last bit");

      // R5/R6 back-to-back
      send_tx(8'h81, 1, 0, "R2");
      send_tx(8'hC3, 1, 0, "R2");
      rd_chk(2'd3, 8'h0C, 8'h00, "R5", "empty cleared while pending");
      wait (exp_q.size() == 0);
      #(BPNS);
      rd_chk(2'd3, 8'h0C, 8'h08, "R6", "end held low during second frame");
      wait_tx();
      rd_chk(2'd3, 8'h0C, 8'h0C, "R6", "end after second frame");

      // R4 no marking bit
      bwrite(2'd3, 8'h08);
      bwrite(2'd2, 8'h03);
      send_tx(8'h3E, 0, 0, "R4");
      wait_tx();
      bwrite(2'd2, 8'h0F);
      send_tx(8'h71, 0, 0, "R4");
      wait_tx();
      bwrite(2'd2, 8'h07);

      // R7 clear without prior read: no effect
      bwrite(2'd3, 8'h08);
      bwrite(2'd3, 8'h00);
      #(2 * BPNS);
      rd_chk(2'd3, 8'hFF, 8'h0C, "R7", "unarmed clear ignored");
      // armed clear: resend held byte
      push_exp(8'h71, 1, 0, "R7");
      bwrite(2'd3, 8'h00);
      rd_chk(2'd3, 8'hFF, 8'h08, "R7", "armed clear dropped end");
      wait_tx();
      rd_chk(2'd3, 8'hFF, 8'h0C, "R7", "end after resend");

      // R8 abort
      mon_en = 0;
      bwrite(2'd0, 8'h55);
      rd_chk(2'd3, 8'h04, 8'h00, "R8", "end low during frame");
      bwrite(2'd2, 8'h06);
      rd_chk(2'd3, 8'h04, 8'h04, "R8", "end set by disable");
      chk(txd == 1'b1, "R8", "line high after abort", txd, 1);
      #(2 * BPNS);
      mon_en = 1;
      bwrite(2'd2, 8'h07);

      // R10 receive
      send_rx(8'hA5, 1, 1);
      rd_chk(2'd1, 8'hFF, 8'hA5, "R10", "rx byte");
      rd_chk(2'd3, 8'h02, 8'h02, "R10", "rx marking 1");
      send_rx(8'h3C, 1, 0);
      rd_chk(2'd1, 8'hFF, 8'h3C, "R10", "rx byte");
      rd_chk(2'd3, 8'h02, 8'h00, "R10", "rx marking 0");
      send_rx(8'hC6, 1, 1);
      bwrite(2'd3, 8'h08);
      rd_chk(2'd3, 8'h02, 8'h02, "R10", "rx marking not writable");
      bwrite(2'd2, 8'h03);
      send_rx(8'h19, 0, 0);
      rd_chk(2'd1, 8'hFF, 8'h19, "R10", "rx byte plain format");
      rd_chk(2'd3, 8'h02, 8'h02, "R10", "rx marking kept outside format");

      // R11 receive disabled
      bwrite(2'd2, 8'h05);
      send_rx(8'h77, 1, 0);
      rd_chk(2'd1, 8'hFF, 8'h19, "R11", "rx data held while disabled");
      rd_chk(2'd3, 8'h02, 8'h02, "R11", "rx marking held while disabled");

      // R12 glitch rejection
      bwrite(2'd2, 8'h07);
      @(negedge clk);
      rxd = 0; #(3 * TICK_DIV * CP); rxd = 1;
      #(2 * BPNS);
      rd_chk(2'd1, 8'hFF, 8'h19, "R12", "glitch loads nothing");
      send_rx(8'hE2, 1, 0);
      rd_chk(2'd1, 8'hFF, 8'hE2, "R12", "frame after glitch");
      rd_chk(2'd3, 8'h02, 8'h00, "R12", "marking after glitch");

      #(BPNS);
      chk(exp_q.size() == 0, "R2", "all queued frames seen", exp_q.size(), 0);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule